// File: doc/BRIEF.md
# GPIO Bank Register File with Per-Pin Masked Writes

This block holds the software-visible state of one bank of general-purpose pins, arranged as four ports of eight pins. A simple 32-bit memory-mapped bus reads and writes the registers. Each port has three writable 8-bit registers and one read-only register:

- a pin-mode register, which marks a pin as software-controlled and goes out to the pad multiplexer;
- a drive-enable register;
- a drive-value register;
- an input-level register.

The block drives the drive-enable and drive-value bits toward the pads. It samples the pad levels through a two-stage synchronizer.

Every writable register can also be reached at a second, aliased address. A write to that alias carries a per-pin select byte and a value byte. Only the selected pins change, so several agents can update different pins of one port without a read-modify-write sequence. This is the feature the block exists for. A plain write replaces the whole register.

Reads return data one clock after the request, and the read data is held until the next read. Decoded addresses that map to nothing read as zero, and writes to them are dropped.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every pin-mode, drive-enable and drive-value bit is 0. The pad-facing outputs `pin_mode`, `pad_oe` and `pad_out` are all 0, and every writable register reads back 0.
- R2: A write with address bit 11 clear replaces all 8 bits of the addressed register with `bus_wdata[7:0]`. Data bits [31:8] are ignored. A read returns the 8-bit value in bits [7:0] with bits [31:8] zero.
- R3: A write with address bit 11 set uses `bus_wdata[15:8]` as a pin select and `bus_wdata[7:0]` as values. Each selected pin n takes value bit n. Each unselected pin keeps its old value.
- R4: An aliased write whose select byte is zero leaves the register unchanged.
- R5: A read at an aliased address (bit 11 set) returns the same value as the plain address.
- R6: The input-level register at group offset 0x30 returns the synchronized pad levels. Plain and aliased writes to it change nothing, and they also leave every pad-facing output unchanged.
- R7: A pad level change seen at clock edge k reaches the input-level register after two edges. A read issued at edge k or k+1 returns the old level, and a read issued at edge k+2 returns the new level.
- R8: Pin p of port i is bit 8*i+p of the pad-facing outputs. `pad_oe` mirrors the drive-enable registers, `pad_out` mirrors the drive-value registers and `pin_mode` mirrors the pin-mode registers. Each output changes on the clock edge that accepts the write.
- R9: Address bits [3:2] select the port (4-byte spacing). Address bits [6:4] select the register group: 0 pin-mode, 1 drive-enable, 2 drive-value, 3 input-level. A write reaches only the addressed port and group.
- R10: An address with any of bits [10:7] set, or with a group code of 4 to 7, reads 0 and ignores writes.
- R11: `bus_rdata` is loaded on the clock edge after a read request (`bus_cs` high, `bus_we` low). It holds its value through write cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the bank window |
| bus_wdata | input | 32 | Write data (select byte in [15:8] on aliased writes) |
| bus_rdata | output | 32 | Registered read data |
| pin_mode | output | 32 | Per-pin software-control flag toward the pad multiplexer |
| pad_oe | output | 32 | Per-pin drive enable toward the pads |
| pad_out | output | 32 | Per-pin drive value toward the pads |
| pad_in | input | 32 | Asynchronous pad levels |

## Verification
The masked update is tried with three select patterns, each of which separates a correct merge from a simple overwrite or a dropped write:
- a partial select over a register already holding mixed bits;
- an all-ones select;
- an empty select.

Plain writes carry non-zero upper data bits, so a design that wrongly applies the alias merge on a plain write is caught. Ports and groups are filled with distinct values, so any aliasing between them appears on the pad outputs. Three reads are issued back to back while a pad level changes, which pins the synchronizer depth to exactly two stages.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Register group codes carried in address bits [6:4]
  typedef enum logic [2:0] {
    GRP_MODE = 3'd0,
    GRP_DREN = 3'd1,
    GRP_DVAL = 3'd2,
    GRP_LVL  = 3'd3
  } grp_e;

  localparam int unsigned PORT_LSB  = 2;   // 4-byte port spacing
  localparam int unsigned GRP_LSB   = 4;   // 0x10 group spacing
  localparam int unsigned WIN_LSB   = 7;   // bits [10:7] must be zero
  localparam int unsigned ALIAS_BIT = 11;  // +0x800 masked alias
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] sel,
  input  logic [WIDTH-1:0] wval,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= (q & ~sel) | (wval & sel);
  end

  // Unselected bits survive an accepted write (R3)
  p_unsel_keep_r3: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (((q ^ $past(q)) & ~$past(sel)) == '0));

  // Selected bits follow the written value (R2, R3)
  p_sel_take_r3: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (((q ^ $past(wval)) & $past(sel)) == '0));

  // Without a write the register holds (R4, R10)
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> (q == $past(q)));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // Edges since reset, saturating at 2, so the check never looks into reset
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 2'd2) age <= 2'(age + 2'd1);
  end

  p_two_stage_r7: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int PORTS  = 4,   // power of two, at most 4
  parameter int PINS   = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_cs,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [PORTS*PINS-1:0] pin_mode,
  output logic [PORTS*PINS-1:0] pad_oe,
  output logic [PORTS*PINS-1:0] pad_out,
  input  logic [PORTS*PINS-1:0] pad_in
);

  localparam int NPIN   = PORTS * PINS;
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  // Address decode
  logic              win_ok;
  logic              is_alias;
  logic [2:0]        grp;
  logic [PORT_W-1:0] port_idx;
  logic [PINS-1:0]   wsel;
  logic [PINS-1:0]   wval;
  logic              do_wr;

  assign win_ok   = (bus_addr[ALIAS_BIT-1:WIN_LSB] == '0);
  assign is_alias = bus_addr[ALIAS_BIT];
  assign grp      = bus_addr[WIN_LSB-1:GRP_LSB];
  assign port_idx = bus_addr[PORT_LSB +: PORT_W];
  assign wsel     = is_alias ? bus_wdata[PINS +: PINS] : '1;
  assign wval     = bus_wdata[PINS-1:0];
  assign do_wr    = bus_cs && bus_we && win_ok;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[PORT_LSB-1:0], bus_wdata[DATA_W-1:2*PINS]};

  // Per-port writable registers
  logic [PORTS-1:0][PINS-1:0] mode_q;
  logic [PORTS-1:0][PINS-1:0] dren_q;
  logic [PORTS-1:0][PINS-1:0] dval_q;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic port_hit;
    assign port_hit = do_wr && (port_idx == PORT_W'(p));

    gpio_mask_reg #(.WIDTH(PINS)) u_mode (
      .clk(clk), .rst(rst),
      .wr_en(port_hit && (grp == GRP_MODE)),
      .sel(wsel), .wval(wval), .q(mode_q[p])
    );
    gpio_mask_reg #(.WIDTH(PINS)) u_dren (
      .clk(clk), .rst(rst),
      .wr_en(port_hit && (grp == GRP_DREN)),
      .sel(wsel), .wval(wval), .q(dren_q[p])
    );
    gpio_mask_reg #(.WIDTH(PINS)) u_dval (
      .clk(clk), .rst(rst),
      .wr_en(port_hit && (grp == GRP_DVAL)),
      .sel(wsel), .wval(wval), .q(dval_q[p])
    );
  end

  // Pad input synchronizer
  logic [NPIN-1:0]            lvl_flat;
  logic [PORTS-1:0][PINS-1:0] lvl_q;

  gpio_in_sync #(.WIDTH(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(lvl_flat)
  );
  assign lvl_q = lvl_flat;

  // Pad-facing outputs come straight from registers
  assign pin_mode = mode_q;
  assign pad_oe   = dren_q;
  assign pad_out  = dval_q;

  // Read path: one registered stage
  logic [PINS-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (win_ok) begin
      case (grp)
        GRP_MODE: rd_val = mode_q[port_idx];
        GRP_DREN: rd_val = dren_q[port_idx];
        GRP_DVAL: rd_val = dval_q[port_idx];
        GRP_LVL:  rd_val = lvl_q[port_idx];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_cs && !bus_we) bus_rdata <= DATA_W'(rd_val);
  end

  // Unmapped reads return zero (R10)
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    $past(bus_cs && !bus_we && !win_ok) |-> (bus_rdata == '0));

  // Read data stays put outside read cycles (R11)
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_cs && !bus_we) |-> (bus_rdata == $past(bus_rdata)));

  // Upper read bits are always zero (R2)
  p_rdata_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[DATA_W-1:PINS] == '0));

endmodule

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cs = 1'b0;
  logic            we = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NPIN-1:0] pin_mode, pad_oe, pad_out;
  logic [NPIN-1:0] pad_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk(clk), .rst(rst), .bus_cs(cs), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_mode(pin_mode),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [11:0] a;
    string       tag;
  } item_t;
  item_t sb[$];

  function automatic void chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endfunction

  // Driver tasks: change inputs on the falling edge only
  task automatic wr(logic [11:0] a, logic [31:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    item_t it;
    it.exp = exp; it.a = a; it.tag = tag;
    sb.push_back(it);
    cs = 1'b1; we = 1'b0; addr = a; wdata = '0;
    @(negedge clk);
    cs = 1'b0;
  endtask

  // Monitor: a read accepted at a rising edge is compared at the next falling edge
  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= cs & ~we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty got=%h exp=none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk($sformatf("%s addr=%h", it.tag, it.a), rdata, it.exp);
      end
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp<=20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 pin_mode", pin_mode, 32'h0);
    for (int p = 0; p < 4; p++) begin
      rd(12'(p*4 + 12'h000), 32'h0, "R1 mode");
      rd(12'(p*4 + 12'h010), 32'h0, "R1 dren");
      rd(12'(p*4 + 12'h020), 32'h0, "R1 dval");
    end

    // R2: plain write replaces all bits, upper data ignored
    wr(12'h024, 32'h0000_00A5);
    rd(12'h024, 32'h0000_00A5, "R2 full replace");
    wr(12'h018, 32'hFFFF_FF3C);
    rd(12'h018, 32'h0000_003C, "R2 upper ignored");
    // R8: pad outputs follow on the accepting edge
    chk("R8 pad_out", pad_out, 32'h0000_A500);
    chk("R8 pad_oe", pad_oe, 32'h003C_0000);

    // R3: masked merge, partial select
    wr(12'h824, 32'h0000_0F0A);
    rd(12'h024, 32'h0000_00AA, "R3 partial select");
    // R5: alias read equals plain read
    rd(12'h824, 32'h0000_00AA, "R5 alias read");
    // R4: empty select changes nothing
    wr(12'h824, 32'h0000_00FF);
    rd(12'h024, 32'h0000_00AA, "R4 empty select");
    chk("R4 pad_out", pad_out, 32'h0000_AA00);

    // R3: all-ones select, then clear two edge pins
    wr(12'h800, 32'h0000_FFFF);
    chk("R3 all-ones select", pin_mode, 32'h0000_00FF);
    wr(12'h800, 32'h0000_8100);
    rd(12'h000, 32'h0000_007E, "R3 clear pins 0 and 7");

    // R9: ports and groups are independent
    wr(12'h00C, 32'h0000_005A);
    rd(12'h000, 32'h0000_007E, "R9 port0 mode");
    rd(12'h00C, 32'h0000_005A, "R9 port3 mode");
    rd(12'h008, 32'h0000_0000, "R9 port2 mode");
    rd(12'h02C, 32'h0000_0000, "R9 port3 dval");
    chk("R9 pin_mode", pin_mode, 32'h5A00_007E);

    // R11: read data holds through writes and idles
    wr(12'h014, 32'h0000_0011);
    @(negedge clk);
    chk("R11 rdata hold", rdata, 32'h0000_0000);
    rd(12'h014, 32'h0000_0011, "R9 port1 dren");

    // R6: input level visible after synchronization
    pad_in = 32'h0096_0000;
    repeat (3) @(negedge clk);
    rd(12'h038, 32'h0000_0096, "R6 level read");

    // R7: exact two-stage delay, reads at edges k, k+1, k+2
    pad_in = 32'h0069_0000;
    rd(12'h038, 32'h0000_0096, "R7 edge k");
    rd(12'h038, 32'h0000_0096, "R7 edge k+1");
    rd(12'h038, 32'h0000_0069, "R7 edge k+2");

    // R6: writes to the input group change nothing
    wr(12'h038, 32'h0000_00FF);
    wr(12'h838, 32'h0000_FF00);
    rd(12'h038, 32'h0000_0069, "R6 write ignored");
    chk("R6 pad_out", pad_out, 32'h0000_AA00);
    chk("R6 pad_oe", pad_oe, 32'h003C_1100);
    chk("R6 pin_mode", pin_mode, 32'h5A00_007E);

    // R10: unmapped group and window bits
    wr(12'h048, 32'h0000_00FF);
    rd(12'h048, 32'h0000_0000, "R10 group 4 read");
    wr(12'h0A4, 32'h0000_0000);
    rd(12'h0A4, 32'h0000_0000, "R10 window bit read");
    rd(12'h024, 32'h0000_00AA, "R10 dval untouched");
    chk("R10 pad_out", pad_out, 32'h0000_AA00);
    chk("R10 pad_oe", pad_oe, 32'h003C_1100);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover got=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule